// File: doc/BRIEF.md
# Page Write Buffer and Write-Cycle Controller

This block sits behind a two-wire serial memory protocol engine and in front of a 1,024-byte array. The protocol engine tells it when a transfer opens (with a 2-bit block select and a read/write flag), when a word address byte arrives, when a data byte arrives, when the master asks for the next read byte, and when a stop condition is seen. The block keeps the 10-bit array address and collects up to sixteen data bytes of a write transfer in a page buffer. It does not touch the array until the stop condition.

At a stop that ends a write transfer with at least one accepted byte, the block raises `busy` for a fixed number of clock cycles. During that time it copies the received bytes into their page slots in the array. While `busy` is high, every request from the protocol engine is ignored. A write-protect input guards the upper half of the array. Reads return one byte per request and step through the whole array.

Top module: `page_write_ctrl`

## Requirements
- R1: After reset, `busy`, `byte_done` and `fetch_done` are low.
- R2: Data bytes of a write transfer are placed at consecutive addresses, starting from the loaded word address. They can be read back once the write cycle has finished.
- R3: During a write, only address bits 3:0 advance and they wrap from 15 to 0. Bits 9:4 stay fixed, so a 17th or later byte overwrites the slot that was filled sixteen bytes earlier.
- R4: Only the page slots that received a byte are committed. Every other byte of the page keeps its previous content.
- R5: A stop that ends a write transfer with at least one accepted byte raises `busy` from the next cycle. `busy` then stays high for exactly `WR_CYCLES` cycles.
- R6: While `busy` is high, `sel_go`, `word_go`, `byte_go`, `fetch_go` and `stop_go` have no effect. No response is produced, and the address and transfer mode do not change.
- R7: A write transfer stopped before any byte was accepted starts no write cycle: `busy` stays low and the array is unchanged.
- R8: When `wp_in` is 1 and address bit 9 is 1, a data byte is answered with `byte_ack` = 0. The byte is not stored and does not advance the address.
- R9: When `wp_in` is 0, or address bit 9 is 0, every data byte is answered with `byte_ack` = 1.
- R10: Each read advances the full 10-bit address by one, wrapping from 1023 to 0.
- R11: The array address is formed from `sel_blk` (bits 9:8) and the word address (bits 7:0). `sel_go` replaces only bits 9:8 and keeps the word address.
- R12: `byte_done` (write mode) follows `byte_go` one cycle later. `fetch_done` with `fetch_byte` (read mode) follows `fetch_go` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_in | input | 1 | Upper-half write protect |
| sel_go | input | 1 | Transfer opened for this device |
| sel_blk | input | 2 | Block select from the device address |
| sel_read | input | 1 | 1 = read transfer, 0 = write transfer |
| word_go | input | 1 | Word address byte received |
| word_val | input | 8 | Word address |
| byte_go | input | 1 | Write data byte received |
| byte_val | input | 8 | Write data byte |
| byte_done | output | 1 | Response strobe for a data byte |
| byte_ack | output | 1 | 1 = byte accepted, 0 = refused |
| fetch_go | input | 1 | Request for the next read byte |
| fetch_done | output | 1 | Read byte valid strobe |
| fetch_byte | output | 8 | Read byte |
| stop_go | input | 1 | Stop condition seen |
| busy | output | 1 | Write cycle in progress |

## Verification
The page path is exercised with four write patterns. A full aligned sixteen-byte page is checked against a partial rewrite of three bytes inside a filled page, which separates a whole-page commit from a masked one. An eighteen-byte burst starting two slots from the page end exposes any carry into the page base. A one-byte write to another block, followed by reads that reselect blocks, checks that the block bits and the word bits are loaded separately. Protected and unprotected halves are written with the lock both set and clear, and an empty write, an ignored burst of requests during `busy`, and a read across address 1023 round out the boundary cases.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    // Array geometry
    localparam int DATA_W     = 8;
    localparam int BLK_W      = 2;
    localparam int WORD_W     = 8;
    localparam int SLOT_W     = 4;
    localparam int ADDR_W     = BLK_W + WORD_W;
    localparam int BASE_W     = ADDR_W - SLOT_W;
    localparam int PAGE_BYTES = 1 << SLOT_W;
    localparam int MEM_BYTES  = 1 << ADDR_W;

    typedef logic [ADDR_W-1:0] arr_addr_t;
    typedef logic [DATA_W-1:0] byte_t;

    localparam arr_addr_t ADDR_ONE = arr_addr_t'(1);

    typedef enum logic [1:0] {
        XF_IDLE  = 2'd0,
        XF_WRITE = 2'd1,
        XF_READ  = 2'd2
    } xfer_e;

    // One write into the page buffer
    typedef struct packed {
        logic              en;
        logic [SLOT_W-1:0] slot;
        byte_t             data;
    } slot_wr_t;

    // One write into the array
    typedef struct packed {
        logic      en;
        arr_addr_t addr;
        byte_t     data;
    } mem_wr_t;

    // Advance inside the page: low bits wrap, page base is kept
    function automatic arr_addr_t page_step(arr_addr_t a);
        logic [SLOT_W-1:0] s;
        s = a[SLOT_W-1:0] + SLOT_W'(1);
        return {a[ADDR_W-1:SLOT_W], s};
    endfunction

    // Upper half refused while the lock input is set
    function automatic logic write_locked(arr_addr_t a, logic wp);
        return wp & a[ADDR_W-1];
    endfunction

endpackage

// File: rtl/pgw_addr_ctr.sv
module pgw_addr_ctr
    import pgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_blk,
    input  logic [BLK_W-1:0]  blk,
    input  logic              ld_word,
    input  logic [WORD_W-1:0] word,
    input  logic              step_page,
    input  logic              step_lin,
    output arr_addr_t         cur_addr
);

    arr_addr_t nxt;

    always_comb begin
        nxt = cur_addr;
        if (ld_blk) begin
            nxt[ADDR_W-1 -: BLK_W] = blk;
        end else if (ld_word) begin
            nxt[WORD_W-1:0] = word;
        end else if (step_page) begin
            nxt = page_step(cur_addr);
        end else if (step_lin) begin
            nxt = cur_addr + ADDR_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= '0;
        end else begin
            cur_addr <= nxt;
        end
    end

    // R3
    page_base_hold_chk: assert property (@(posedge clk) disable iff (rst)
        step_page && !ld_blk && !ld_word |=>
            cur_addr[ADDR_W-1:SLOT_W] == $past(cur_addr[ADDR_W-1:SLOT_W]));

    // R10
    lin_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        step_lin && !ld_blk && !ld_word && !step_page && (cur_addr == '1) |=>
            cur_addr == '0);

endmodule

// File: rtl/pgw_page_buf.sv
module pgw_page_buf
    import pgw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clear,
    input  slot_wr_t              wr,
    input  logic [SLOT_W-1:0]     rd_slot,
    output byte_t                 rd_data,
    output logic [PAGE_BYTES-1:0] mask
);

    logic [PAGE_BYTES-1:0][DATA_W-1:0] flat;

    generate
        for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
            byte_t q;
            always_ff @(posedge clk) begin
                if (wr.en && (wr.slot == SLOT_W'(g))) begin
                    q <= wr.data;
                end
            end
            assign flat[g] = q;
        end
    endgenerate

    assign rd_data = flat[rd_slot];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            mask <= '0;
        end else if (wr.en) begin
            mask[wr.slot] <= 1'b1;
        end
    end

    // R4
    clear_empty_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> mask == '0);

    // R4
    mark_slot_chk: assert property (@(posedge clk) disable iff (rst)
        wr.en && !clear |=> mask[$past(wr.slot)]);

endmodule

// File: rtl/pgw_commit_seq.sv
module pgw_commit_seq
    import pgw_pkg::*;
#(
    // Must be at least PAGE_BYTES: one slot is copied per busy cycle
    parameter int WR_CYCLES = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [BASE_W-1:0]     base,
    input  logic [PAGE_BYTES-1:0] mask,
    input  byte_t                 slot_data,
    output logic [SLOT_W-1:0]     slot_sel,
    output logic                  busy,
    output mem_wr_t               mem_wr
);

    localparam int CNT_W = $clog2(WR_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST   = CNT_W'(WR_CYCLES - 1);
    localparam logic [CNT_W-1:0] PAGE_N = CNT_W'(PAGE_BYTES);
    localparam logic [CNT_W-1:0] FULL   = CNT_W'(WR_CYCLES);

    logic [CNT_W-1:0]  cnt;
    logic [BASE_W-1:0] base_q;
    logic              in_page;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cnt    <= '0;
            base_q <= '0;
        end else if (start && !busy) begin
            busy   <= 1'b1;
            cnt    <= '0;
            base_q <= base;
        end else if (busy) begin
            if (cnt == LAST) begin
                busy <= 1'b0;
            end
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign slot_sel = cnt[SLOT_W-1:0];
    assign in_page  = busy && (cnt < PAGE_N);

    always_comb begin
        mem_wr.en   = in_page && mask[slot_sel];
        mem_wr.addr = {base_q, slot_sel};
        mem_wr.data = slot_data;
    end

    // Length of the busy window, counted apart from the sequencer
    logic [CNT_W-1:0] run_len;
    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            run_len <= '0;
        end else begin
            run_len <= run_len + CNT_W'(1);
        end
    end

    // R5
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> run_len == FULL);

    // R6
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

endmodule

// File: rtl/pgw_array.sv
module pgw_array
    import pgw_pkg::*;
(
    input  logic      clk,
    input  mem_wr_t   wr,
    input  logic      re,
    input  arr_addr_t raddr,
    output byte_t     rdata
);

    byte_t cells [MEM_BYTES];

    always_ff @(posedge clk) begin
        if (wr.en) begin
            cells[wr.addr] <= wr.data;
        end
        if (re) begin
            rdata <= cells[raddr];
        end
    end

endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl
    import pgw_pkg::*;
#(
    parameter int WR_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wp_in,
    input  logic              sel_go,
    input  logic [BLK_W-1:0]  sel_blk,
    input  logic              sel_read,
    input  logic              word_go,
    input  logic [WORD_W-1:0] word_val,
    input  logic              byte_go,
    input  logic [DATA_W-1:0] byte_val,
    output logic              byte_done,
    output logic              byte_ack,
    input  logic              fetch_go,
    output logic              fetch_done,
    output logic [DATA_W-1:0] fetch_byte,
    input  logic              stop_go,
    output logic              busy
);

    xfer_e                 mode;
    arr_addr_t             cur_addr;
    logic [PAGE_BYTES-1:0] mask;
    logic [SLOT_W-1:0]     commit_slot;
    byte_t                 commit_data;
    mem_wr_t               arr_wr;
    slot_wr_t              buf_wr;

    logic sel_ok, word_ok, byte_ok, fetch_ok, stop_ok;
    logic locked, take_byte, commit_go, buf_clear;

    // Requests are honoured only outside the write cycle
    assign sel_ok   = sel_go   && !busy;
    assign word_ok  = word_go  && !busy && (mode == XF_WRITE);
    assign byte_ok  = byte_go  && !busy && (mode == XF_WRITE);
    assign fetch_ok = fetch_go && !busy && (mode == XF_READ);
    assign stop_ok  = stop_go  && !busy;

    assign locked    = write_locked(cur_addr, wp_in);
    assign take_byte = byte_ok && !locked;
    assign commit_go = stop_ok && (mode == XF_WRITE) && (|mask);
    assign buf_clear = sel_ok && !sel_read;

    always_comb begin
        buf_wr.en   = take_byte;
        buf_wr.slot = cur_addr[SLOT_W-1:0];
        buf_wr.data = byte_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= XF_IDLE;
        end else if (sel_ok) begin
            mode <= sel_read ? XF_READ : XF_WRITE;
        end else if (stop_ok) begin
            mode <= XF_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_done  <= 1'b0;
            byte_ack   <= 1'b0;
            fetch_done <= 1'b0;
        end else begin
            byte_done  <= byte_ok;
            byte_ack   <= take_byte;
            fetch_done <= fetch_ok;
        end
    end

    pgw_addr_ctr u_addr (
        .clk       (clk),
        .rst       (rst),
        .ld_blk    (sel_ok),
        .blk       (sel_blk),
        .ld_word   (word_ok),
        .word      (word_val),
        .step_page (take_byte),
        .step_lin  (fetch_ok),
        .cur_addr  (cur_addr)
    );

    pgw_page_buf u_buf (
        .clk     (clk),
        .rst     (rst),
        .clear   (buf_clear),
        .wr      (buf_wr),
        .rd_slot (commit_slot),
        .rd_data (commit_data),
        .mask    (mask)
    );

    pgw_commit_seq #(
        .WR_CYCLES (WR_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (commit_go),
        .base      (cur_addr[ADDR_W-1:SLOT_W]),
        .mask      (mask),
        .slot_data (commit_data),
        .slot_sel  (commit_slot),
        .busy      (busy),
        .mem_wr    (arr_wr)
    );

    pgw_array u_arr (
        .clk   (clk),
        .wr    (arr_wr),
        .re    (fetch_ok),
        .raddr (cur_addr),
        .rdata (fetch_byte)
    );

    // R5
    commit_start_chk: assert property (@(posedge clk) disable iff (rst)
        commit_go |=> busy);

    // R7
    empty_stop_chk: assert property (@(posedge clk) disable iff (rst)
        stop_ok && (mask == '0) && !busy |=> !busy);

    // R8
    locked_nack_chk: assert property (@(posedge clk) disable iff (rst)
        byte_ok && locked |=> byte_done && !byte_ack);

    // R6
    quiet_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) |-> !byte_done && !fetch_done);

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) |-> $stable(cur_addr) && $stable(mode));

    // R12
    fetch_resp_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_ok |=> fetch_done);

endmodule

// File: tb/test_page_write_ctrl.sv
module test_page_write_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WR_T       = 24;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wp_in = 1'b0;
    logic       sel_go = 1'b0;
    logic [1:0] sel_blk = '0;
    logic       sel_read = 1'b0;
    logic       word_go = 1'b0;
    logic [7:0] word_val = '0;
    logic       byte_go = 1'b0;
    logic [7:0] byte_val = '0;
    logic       byte_done, byte_ack;
    logic       fetch_go = 1'b0;
    logic       fetch_done;
    logic [7:0] fetch_byte;
    logic       stop_go = 1'b0;
    logic       busy;

    always #(CLK_PERIOD / 2) clk = ~clk;

    page_write_ctrl #(
        .WR_CYCLES (WR_T)
    ) i_page_write_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wp_in      (wp_in),
        .sel_go     (sel_go),
        .sel_blk    (sel_blk),
        .sel_read   (sel_read),
        .word_go    (word_go),
        .word_val   (word_val),
        .byte_go    (byte_go),
        .byte_val   (byte_val),
        .byte_done  (byte_done),
        .byte_ack   (byte_ack),
        .fetch_go   (fetch_go),
        .fetch_done (fetch_done),
        .fetch_byte (fetch_byte),
        .stop_go    (stop_go),
        .busy       (busy)
    );

    typedef struct {
        bit         is_rd;
        logic [7:0] val;
        string      req;
    } exp_t;

    exp_t       pend[$];
    int         n_chk = 0;
    int         n_bad = 0;
    bit         ended = 1'b0;
    logic [7:0] model [1024];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // Scoreboard monitor: responses are compared in arrival order.
    // R12: a response is due on the negedge right after its request.
    always @(negedge clk) begin
        if (!rst) begin
            if (byte_done === 1'b1) begin
                if (pend.size() == 0) begin
                    chk(1'b0, "R6", "unexpected byte response", 32'(byte_ack), 32'hFFFF);
                end else begin
                    exp_t e;
                    e = pend.pop_front();
                    chk(!e.is_rd && (byte_ack === e.val[0]), e.req, "byte_ack",
                        32'(byte_ack), 32'(e.val[0]));
                end
            end
            if (fetch_done === 1'b1) begin
                if (pend.size() == 0) begin
                    chk(1'b0, "R6", "unexpected read response", 32'(fetch_byte), 32'hFFFF);
                end else begin
                    exp_t e;
                    e = pend.pop_front();
                    chk(e.is_rd && (fetch_byte === e.val), e.req, "fetch_byte",
                        32'(fetch_byte), 32'(e.val));
                end
            end
        end
    end

    // Driver tasks: called at a negedge, each occupies one cycle
    task automatic op_sel(input logic [1:0] blk, input logic rd);
        sel_blk = blk; sel_read = rd; sel_go = 1'b1;
        @(negedge clk); sel_go = 1'b0;
    endtask

    task automatic op_word(input logic [7:0] w);
        word_val = w; word_go = 1'b1;
        @(negedge clk); word_go = 1'b0;
    endtask

    task automatic op_byte(input logic [7:0] b, input bit ack, input string req,
                           input bit track = 1'b1);
        exp_t e;
        byte_val = b; byte_go = 1'b1;
        if (track) begin
            e.is_rd = 1'b0; e.val = {7'd0, ack}; e.req = req;
            pend.push_back(e);
        end
        @(negedge clk); byte_go = 1'b0;
    endtask

    task automatic op_fetch(input logic [7:0] exp, input string req,
                            input bit track = 1'b1);
        exp_t e;
        fetch_go = 1'b1;
        if (track) begin
            e.is_rd = 1'b1; e.val = exp; e.req = req;
            pend.push_back(e);
        end
        @(negedge clk); fetch_go = 1'b0;
    endtask

    task automatic op_stop();
        stop_go = 1'b1;
        @(negedge clk); stop_go = 1'b0;
    endtask

    task automatic expect_commit(input string req);
        int n = 0;
        chk(busy === 1'b1, req, "busy after stop", 32'(busy), 32'd1);
        while (busy === 1'b1) begin
            n++;
            @(negedge clk);
        end
        chk(n == WR_T, req, "busy length", 32'(n), 32'(WR_T));
    endtask

    task automatic expect_no_commit(input string req);
        for (int i = 0; i < 4; i++) begin
            chk(busy === 1'b0, req, "busy after empty stop", 32'(busy), 32'd0);
            @(negedge clk);
        end
    endtask

    // Write n bytes (value v0+i) from {blk,w}; model follows the in-page wrap
    task automatic write_run(input logic [1:0] blk, input logic [7:0] w,
                             input int n, input logic [7:0] v0, input string req);
        op_sel(blk, 1'b0);
        op_word(w);
        for (int i = 0; i < n; i++) begin
            logic [3:0] s;
            s = w[3:0] + 4'(i);
            op_byte(v0 + 8'(i), 1'b1, req);
            model[{blk, w[7:4], s}] = v0 + 8'(i);
        end
        op_stop();
        expect_commit("R5");
    endtask

    // Read n bytes starting at {blk,w} and compare with the model
    task automatic read_run(input logic [1:0] blk, input logic [7:0] w,
                            input int n, input string req);
        logic [9:0] a;
        op_sel(blk, 1'b0);
        op_word(w);
        op_sel(blk, 1'b1);
        a = {blk, w};
        for (int i = 0; i < n; i++) begin
            op_fetch(model[a], req);
            a = a + 10'd1;
        end
        op_stop();
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        chk(1'b0, "watchdog", "run did not end", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk(busy === 1'b0, "R1", "busy", 32'(busy), 32'd0);
        chk(byte_done === 1'b0, "R1", "byte_done", 32'(byte_done), 32'd0);
        chk(fetch_done === 1'b0, "R1", "fetch_done", 32'(fetch_done), 32'd0);

        // R2, R9: full aligned page in block 1
        write_run(2'd1, 8'h20, 16, 8'h40, "R9");
        read_run(2'd1, 8'h20, 16, "R2");

        // R11: same word in block 2 is a different byte; sel keeps word bits
        write_run(2'd2, 8'h20, 1, 8'hA5, "R9");
        op_sel(2'd2, 1'b0);
        op_word(8'h20);
        op_sel(2'd2, 1'b1);
        op_fetch(model[10'h220], "R11");
        op_sel(2'd1, 1'b1);
        op_fetch(model[10'h121], "R11");
        op_stop();

        // R4: partial rewrite leaves the rest of the page untouched
        write_run(2'd0, 8'h30, 16, 8'h10, "R9");
        write_run(2'd0, 8'h35, 3, 8'hE0, "R4");
        read_run(2'd0, 8'h30, 16, "R4");

        // R3: eighteen bytes from slot 14 wrap inside the page
        write_run(2'd0, 8'h0E, 18, 8'h60, "R3");
        read_run(2'd0, 8'h00, 16, "R3");
        read_run(2'd0, 8'h10, 1, "R3");

        // R7: write transfer with no data byte
        op_sel(2'd0, 1'b0);
        op_word(8'h50);
        op_stop();
        expect_no_commit("R7");

        // R8: protected upper half refuses data, lower half still accepts (R9)
        write_run(2'd3, 8'h10, 1, 8'h3C, "R9");
        wp_in = 1'b1;
        op_sel(2'd3, 1'b0);
        op_word(8'h10);
        op_byte(8'h77, 1'b0, "R8");
        op_byte(8'h78, 1'b0, "R8");
        op_stop();
        expect_no_commit("R8");
        write_run(2'd1, 8'h40, 1, 8'h55, "R9");
        read_run(2'd3, 8'h10, 2, "R8");
        wp_in = 1'b0;
        read_run(2'd1, 8'h40, 1, "R9");

        // R6: requests during the write cycle are ignored
        write_run(2'd1, 8'h80, 4, 8'hC0, "R9");
        op_sel(2'd1, 1'b0);
        op_word(8'h80);
        op_byte(8'hD0, 1'b1, "R9");
        op_byte(8'hD1, 1'b1, "R9");
        model[10'h180] = 8'hD0;
        model[10'h181] = 8'hD1;
        op_stop();
        chk(busy === 1'b1, "R6", "busy at stop", 32'(busy), 32'd1);
        op_sel(2'd2, 1'b1);
        op_word(8'h00);
        op_byte(8'hEE, 1'b0, "R6", 1'b0);
        op_fetch(8'h00, "R6", 1'b0);
        op_stop();
        while (busy === 1'b1) @(negedge clk);
        op_sel(2'd1, 1'b1);
        op_fetch(model[10'h182], "R6");
        op_fetch(model[10'h183], "R6");
        op_stop();
        read_run(2'd1, 8'h80, 2, "R6");

        // R10: read crosses from the last byte to byte 0
        write_run(2'd3, 8'hFF, 1, 8'h9A, "R9");
        write_run(2'd0, 8'h00, 1, 8'h9B, "R9");
        op_sel(2'd3, 1'b0);
        op_word(8'hFF);
        op_sel(2'd3, 1'b1);
        op_fetch(8'h9A, "R10");
        op_fetch(8'h9B, "R10");
        op_stop();

        repeat (4) @(negedge clk);
        chk(pend.size() == 0, "R12", "responses still outstanding",
            32'(pend.size()), 32'd0);
        finish_run();
    end

endmodule